// File: doc/BRIEF.md
# Video-RAM Block Copy Engine

This block copies data from the system address space into video RAM in units of 16-byte blocks. Software loads a source address and a destination address as byte-wide registers, then writes a control byte. That control write checks the addresses and latches them. Depending on the mode and the current video phase, it also starts a copy.

There are two modes. A general copy moves the whole programmed length in one burst. A paced copy moves one block each time the video timing enters its horizontal-blanking phase, until the programmed number of blocks has been sent. During a copy the CPU is held off through a stall output. One byte moves every two clock cycles: the engine reads the byte from the memory read port, then writes it through the video-RAM write port. When a run ends, the advanced pointers are written back into the address registers, and the control register shows how much work remains.

Top module: `vdma_top`

## Requirements
- R1: After reset, all four address registers read 0x00, the control register reads 0xFF, no copy is armed and `cpu_stall` is low. Register select codes are 0 = source high, 1 = source low, 2 = destination high, 3 = destination low, 4 = control.
- R2: A control write takes the source as {high,low} with bits 3:0 forced to zero. It takes the destination as ({high,low} AND 0x1FF0) OR 0x8000.
- R3: A control write whose masked source falls in 0x8000..0x9FFF is refused. No byte is copied, the stall stays low, and the control register and armed state keep their previous values.
- R4: Control bit 7 set selects paced mode. Bits 6:0 give N, and the total length is (N+1)×16 bytes. An accepted control write stores N with bit 7 cleared in the control register.
- R5: An accepted control write starts a copy at once when neither the armed state before the write nor the new bit 7 is paced, or when `video_mode` is 0 (horizontal blank) in the write cycle. In that case a general copy moves the full length and a paced copy moves one block.
- R6: While copying, `cpu_stall` is high for exactly two cycles per byte. Each byte produces one video-RAM write, at consecutive destinations, carrying the memory data read at consecutive sources.
- R7: When a run ends, the advanced source and destination are written into the four address registers (high byte first), in the same cycle as the stall is released.
- R8: After a general copy ends, the control register reads 0xFF.
- R9: While paced mode is armed, each entry of `video_mode` into 0 from another value copies exactly one block, and the control register is decremented after it. The run that wraps the control register to 0xFF disarms paced mode, and later entries copy nothing.
- R10: A control write with bit 7 clear while paced mode is armed and `video_mode` is not 0 disarms paced mode without copying. The control register takes the new length.
- R11: A control write that arrives while a copy is running is ignored. The run length and the final control value are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for writes |
| cfg_wdata | input | 8 | Register write data |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 8 | Readback data (0xFF for unused codes) |
| video_mode | input | 2 | Current video phase, 0 = horizontal blank |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid in the strobe cycle |
| vram_we | output | 1 | Video-RAM write strobe |
| vram_addr | output | 16 | Video-RAM write address |
| vram_wdata | output | 8 | Video-RAM write data |
| cpu_stall | output | 1 | CPU hold while a copy runs |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit registers, 16-byte blocks, a 7-bit length field and an 8 KiB video window at 0x8000. With these values the bench can probe both edges of the refused window (0x7FF0 and 0xA000 are accepted, 0x8800 and 0x9FFF are refused). It can also run a paced sequence of three blocks through the 0x00 to 0xFF wrap, and a 64-byte burst long enough that a stray control write lands in the middle of it. Each expected video-RAM write is queued from the address rules and compared as it appears.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   typedef enum logic [2:0] {
      SEL_SRC_HI = 3'd0,
      SEL_SRC_LO = 3'd1,
      SEL_DST_HI = 3'd2,
      SEL_DST_LO = 3'd3,
      SEL_CTRL   = 3'd4
   } vdma_sel_e;

   typedef enum logic {
      PH_FETCH = 1'b0,
      PH_STORE = 1'b1
   } vdma_phase_e;
endpackage

// File: rtl/vdma_regfile.sv
module vdma_regfile import vdma_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              ctrl_take,
   input  logic              done,
   input  logic [ADDR_W-1:0] done_src,
   input  logic [ADDR_W-1:0] done_dst,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] src_raw,
   output logic [ADDR_W-1:0] dst_raw,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              armed_q
);
   localparam int NREG = 4;

   logic [DATA_W-1:0] areg_q [NREG];
   logic [DATA_W-1:0] wb_val [NREG];

   always_comb begin
      wb_val[0] = done_src[ADDR_W-1:DATA_W];
      wb_val[1] = done_src[DATA_W-1:0];
      wb_val[2] = done_dst[ADDR_W-1:DATA_W];
      wb_val[3] = done_dst[DATA_W-1:0];
   end

   for (genvar g = 0; g < NREG; g++) begin : g_areg
      always_ff @(posedge clk) begin
         if (!rst_n)
            areg_q[g] <= '0;
         else if (done)
            areg_q[g] <= wb_val[g];
         else if (cfg_we && cfg_sel == 3'(g))
            areg_q[g] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '1;
         armed_q <= 1'b0;
      end else if (done) begin
         if (armed_q) begin
            ctrl_q <= ctrl_q - DATA_W'(1);
            if (ctrl_q == '0) armed_q <= 1'b0;
         end else begin
            ctrl_q <= '1;
         end
      end else if (ctrl_take) begin
         ctrl_q  <= {1'b0, cfg_wdata[DATA_W-2:0]};
         armed_q <= cfg_wdata[DATA_W-1];
      end
   end

   assign src_raw = {areg_q[0], areg_q[1]};
   assign dst_raw = {areg_q[2], areg_q[3]};

   always_comb begin
      unique case (rd_sel)
         SEL_SRC_HI: rd_data = areg_q[0];
         SEL_SRC_LO: rd_data = areg_q[1];
         SEL_DST_HI: rd_data = areg_q[2];
         SEL_DST_LO: rd_data = areg_q[3];
         SEL_CTRL:   rd_data = ctrl_q;
         default:    rd_data = '1;
      endcase
   end

   AST_CTRL_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (ctrl_q == '1) || (ctrl_q == $past(ctrl_q) - DATA_W'(1))); // R9
   AST_ARMED_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> !ctrl_q[DATA_W-1]); // R4
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine import vdma_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_load,
   input  logic [ADDR_W-1:0] ptr_src,
   input  logic [ADDR_W-1:0] ptr_dst,
   input  logic              go,
   input  logic [CNT_W-1:0]  go_len,
   output logic              busy,
   output logic              last,
   output logic [ADDR_W-1:0] nxt_src,
   output logic [ADDR_W-1:0] nxt_dst,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              vram_we,
   output logic [ADDR_W-1:0] vram_addr,
   output logic [DATA_W-1:0] vram_wdata
);
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] byte_q;
   vdma_phase_e       phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         byte_q  <= '0;
         busy    <= 1'b0;
         phase_q <= PH_FETCH;
      end else begin
         if (ptr_load) begin
            src_q <= ptr_src;
            dst_q <= ptr_dst;
         end
         if (go && !busy) begin
            busy    <= 1'b1;
            cnt_q   <= go_len;
            phase_q <= PH_FETCH;
         end else if (busy) begin
            if (phase_q == PH_FETCH) begin
               byte_q  <= mem_rd_data;
               phase_q <= PH_STORE;
            end else begin
               src_q   <= nxt_src;
               dst_q   <= nxt_dst;
               cnt_q   <= cnt_q - CNT_W'(1);
               phase_q <= PH_FETCH;
               if (cnt_q == CNT_W'(1)) busy <= 1'b0;
            end
         end
      end
   end

   assign nxt_src     = src_q + ADDR_W'(1);
   assign nxt_dst     = dst_q + ADDR_W'(1);
   assign mem_rd_en   = busy && (phase_q == PH_FETCH);
   assign mem_rd_addr = src_q;
   assign vram_we     = busy && (phase_q == PH_STORE);
   assign vram_addr   = dst_q;
   assign vram_wdata  = byte_q;
   assign last        = vram_we && (cnt_q == CNT_W'(1));

   AST_STORE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |=> !vram_we); // R6
   AST_FETCH_BEFORE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |-> $past(mem_rd_en)); // R6
   AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy); // R11
endmodule

// File: rtl/vdma_top.sv
module vdma_top import vdma_pkg::*; #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          LEN_W     = 7,
   parameter int          BLK_LOG2  = 4,
   parameter int          VRAM_LOG2 = 13,
   parameter int unsigned VRAM_BASE = 'h8000,
   parameter int          MODE_W    = 2,
   parameter int unsigned HBLANK    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [MODE_W-1:0] video_mode,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              vram_we,
   output logic [ADDR_W-1:0] vram_addr,
   output logic [DATA_W-1:0] vram_wdata,
   output logic              cpu_stall
);
   localparam int                CNT_W     = LEN_W + BLK_LOG2 + 1;
   localparam int                BLK_BYTES = 1 << BLK_LOG2;
   localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'(BLK_BYTES - 1);
   localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'((1 << VRAM_LOG2) - 1);
   localparam logic [ADDR_W-1:0] VBASE     = ADDR_W'(VRAM_BASE);
   localparam logic [ADDR_W-1:0] SRC_MASK  = ~BLK_MASK;
   localparam logic [ADDR_W-1:0] DST_MASK  = WIN_MASK & ~BLK_MASK;

   if (ADDR_W != 2 * DATA_W) begin : g_chk_addr
      $error("ADDR_W must span exactly two register bytes");
   end
   if (LEN_W + 1 != DATA_W) begin : g_chk_len
      $error("control byte must hold the mode bit and the length field");
   end
   if (BLK_LOG2 < 1 || BLK_LOG2 >= VRAM_LOG2 || VRAM_LOG2 >= ADDR_W) begin : g_chk_win
      $error("block and window sizes out of range");
   end
   if ((VRAM_BASE % (1 << VRAM_LOG2)) != 0) begin : g_chk_base
      $error("VRAM_BASE must be aligned to the window size");
   end

   logic [ADDR_W-1:0] src_raw, dst_raw, src_m, dst_m, nxt_src, nxt_dst;
   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  len_full, go_len;
   logic armed_q, busy, last, src_bad, ctrl_wr, ctrl_take, new_paced;
   logic in_blank, blank_prev_q, start_now, blank_go, go;

   assign src_m     = src_raw & SRC_MASK;
   assign dst_m     = (dst_raw & DST_MASK) | VBASE;
   assign src_bad   = (src_m & ~WIN_MASK) == VBASE;
   assign in_blank  = video_mode == MODE_W'(HBLANK);
   assign new_paced = cfg_wdata[DATA_W-1];
   assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL) && !busy;
   assign ctrl_take = ctrl_wr && !src_bad;
   assign start_now = ctrl_take && ((!armed_q && !new_paced) || in_blank);
   assign blank_go  = in_blank && !blank_prev_q && armed_q && !busy && !ctrl_take;
   assign go        = start_now || blank_go;
   assign len_full  = (CNT_W'(cfg_wdata[LEN_W-1:0]) + CNT_W'(1)) << BLK_LOG2;
   assign go_len    = (start_now && !new_paced) ? len_full : CNT_W'(BLK_BYTES);
   assign cpu_stall = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) blank_prev_q <= 1'b1;
      else        blank_prev_q <= in_blank;
   end

   vdma_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .ctrl_take(ctrl_take), .done(last),
      .done_src(nxt_src), .done_dst(nxt_dst),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .src_raw(src_raw), .dst_raw(dst_raw),
      .ctrl_q(ctrl_q), .armed_q(armed_q)
   );

   vdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .ptr_load(ctrl_take), .ptr_src(src_m), .ptr_dst(dst_m),
      .go(go), .go_len(go_len),
      .busy(busy), .last(last),
      .nxt_src(nxt_src), .nxt_dst(nxt_dst),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata)
   );

   AST_REFUSED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && src_bad && !armed_q) |=> !cpu_stall); // R3
   AST_STALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> cpu_stall); // R6
   AST_DISARMED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !cpu_stall && !cfg_we) |=> !cpu_stall); // R9
   AST_WRITEBACK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall) |-> ((src_raw & BLK_MASK) == '0)); // R7
   AST_STORE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |-> ((vram_addr & ~WIN_MASK) == VBASE)); // R2
   AST_CTRL_MARK_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !cpu_stall && !cfg_we) |=> $stable(ctrl_q)); // R8
endmodule

// File: tb/tb_vdma_top.sv
`timescale 1ns/1ps
module tb_vdma_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic [2:0]  rd_sel = 3'd0;
   logic [7:0]  rd_data;
   logic [1:0]  video_mode = 2'd1;
   logic        mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic [7:0]  mem_rd_data;
   logic        vram_we;
   logic [15:0] vram_addr;
   logic [7:0]  vram_wdata;
   logic        cpu_stall;

   int    n_checks = 0;
   int    n_fail = 0;
   int    stall_cnt = 0;
   string cur_req = "R1";
   logic [23:0] exp_q[$];

   always #10 clk = ~clk;

   vdma_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
      .video_mode(video_mode), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .vram_we(vram_we), .vram_addr(vram_addr),
      .vram_wdata(vram_wdata), .cpu_stall(cpu_stall)
   );

   function automatic logic [7:0] mem_fn(logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction

   assign mem_rd_data = mem_fn(mem_rd_addr);

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_stall) stall_cnt++;
         if (vram_we) begin
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL %s: unexpected vram write addr=%h data=%h, expected none",
                        cur_req, vram_addr, vram_wdata);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               if ({vram_addr, vram_wdata} !== e) begin
                  n_fail++;
                  $display("FAIL %s: vram write %h/%h, expected %h/%h",
                           cur_req, vram_addr, vram_wdata, e[23:8], e[7:0]);
               end
            end
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] sel, output logic [7:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic check_reg(string req, logic [2:0] sel, logic [7:0] exp);
      logic [7:0] d;
      rd(sel, d);
      check(req, 32'(d), 32'(exp), $sformatf("register %0d", sel));
   endtask

   task automatic push_run(logic [15:0] src, logic [15:0] dst, int n);
      for (int i = 0; i < n; i++) begin
         logic [15:0] s;
         s = src + 16'(i);
         exp_q.push_back({dst + 16'(i), mem_fn(s)});
      end
   endtask

   task automatic set_addrs(logic [15:0] src, logic [15:0] dst);
      wr(3'd0, src[15:8]); wr(3'd1, src[7:0]);
      wr(3'd2, dst[15:8]); wr(3'd3, dst[7:0]);
   endtask

   task automatic wait_idle(string req, int exp_cycles);
      int guard = 0;
      @(negedge clk);
      while (cpu_stall && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(req, 32'(stall_cnt), 32'(exp_cycles), "stall cycles");
      check(req, 32'(exp_q.size()), 32'd0, "pending expected writes");
   endtask

   task automatic idle_cycles(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      idle_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      cur_req = "R1";
      check("R1", 32'(cpu_stall), 32'd0, "stall after reset");
      check_reg("R1", 3'd0, 8'h00);
      check_reg("R1", 3'd1, 8'h00);
      check_reg("R1", 3'd2, 8'h00);
      check_reg("R1", 3'd3, 8'h00);
      check_reg("R1", 3'd4, 8'hFF);

      // R2 R6 R7 R8: general burst of 32 bytes
      cur_req = "R6";
      video_mode = 2'd1;
      set_addrs(16'h1234, 16'hFF25);
      push_run(16'h1230, 16'h9F20, 32);
      stall_cnt = 0;
      wr(3'd4, 8'h01);
      wait_idle("R6", 64);
      check_reg("R7", 3'd0, 8'h12);
      check_reg("R7", 3'd1, 8'h50);
      check_reg("R7", 3'd2, 8'h9F);
      check_reg("R7", 3'd3, 8'h40);
      check_reg("R8", 3'd4, 8'hFF);

      // R3: refused sources inside the video window
      cur_req = "R3";
      set_addrs(16'h8800, 16'h8000);
      stall_cnt = 0;
      wr(3'd4, 8'h00);
      idle_cycles(4);
      check("R3", 32'(stall_cnt), 32'd0, "stall for 0x8800 source");
      check_reg("R3", 3'd4, 8'hFF);
      wr(3'd0, 8'h9F); wr(3'd1, 8'hFF);
      stall_cnt = 0;
      wr(3'd4, 8'h85);
      video_mode = 2'd0;
      idle_cycles(4);
      check("R3", 32'(stall_cnt), 32'd0, "stall for 0x9FFF source");
      check_reg("R3", 3'd4, 8'hFF);
      video_mode = 2'd1;

      // R2: window edges accepted
      cur_req = "R2";
      set_addrs(16'hA00F, 16'h0000);
      push_run(16'hA000, 16'h8000, 16);
      stall_cnt = 0;
      wr(3'd4, 8'h00);
      wait_idle("R2", 32);
      set_addrs(16'h7FF8, 16'h2345);
      push_run(16'h7FF0, 16'h8340, 16);
      stall_cnt = 0;
      wr(3'd4, 8'h00);
      wait_idle("R2", 32);
      check_reg("R2", 3'd2, 8'h83);
      check_reg("R2", 3'd3, 8'h50);

      // R4 R5 R9: paced mode armed outside blanking, three blocks
      cur_req = "R9";
      video_mode = 2'd2;
      set_addrs(16'h4000, 16'h8100);
      stall_cnt = 0;
      wr(3'd4, 8'h82);
      idle_cycles(4);
      check("R5", 32'(stall_cnt), 32'd0, "no immediate start outside blanking");
      check_reg("R4", 3'd4, 8'h02);
      for (int k = 0; k < 3; k++) begin
         push_run(16'h4000 + 16'(16 * k), 16'h8100 + 16'(16 * k), 16);
         stall_cnt = 0;
         video_mode = 2'd0;
         @(negedge clk);
         wait_idle("R9", 32);
         idle_cycles(4);
         check("R9", 32'(stall_cnt), 32'd32, "one block per blanking entry");
         check_reg("R9", 3'd4, (k == 0) ? 8'h01 : (k == 1) ? 8'h00 : 8'hFF);
         video_mode = 2'd3;
         idle_cycles(2);
      end
      check_reg("R7", 3'd1, 8'h30);
      check_reg("R7", 3'd3, 8'h30);
      stall_cnt = 0;
      video_mode = 2'd0;
      idle_cycles(5);
      check("R9", 32'(stall_cnt), 32'd0, "no copy after wrap");

      // R5: paced write during blanking starts one block at once
      cur_req = "R5";
      set_addrs(16'h0100, 16'h8800);
      push_run(16'h0100, 16'h8800, 16);
      stall_cnt = 0;
      wr(3'd4, 8'h81);
      wait_idle("R5", 32);
      check_reg("R5", 3'd4, 8'h00);
      video_mode = 2'd2;
      idle_cycles(2);
      push_run(16'h0110, 16'h8810, 16);
      stall_cnt = 0;
      video_mode = 2'd0;
      @(negedge clk);
      wait_idle("R9", 32);
      check_reg("R9", 3'd4, 8'hFF);

      // R10: cancel armed paced mode
      cur_req = "R10";
      video_mode = 2'd2;
      set_addrs(16'h2000, 16'h8000);
      stall_cnt = 0;
      wr(3'd4, 8'h85);
      check_reg("R4", 3'd4, 8'h05);
      wr(3'd4, 8'h03);
      idle_cycles(3);
      check("R10", 32'(stall_cnt), 32'd0, "no start on cancel");
      check_reg("R10", 3'd4, 8'h03);
      video_mode = 2'd0;
      idle_cycles(5);
      check("R10", 32'(stall_cnt), 32'd0, "no copy after cancel");
      video_mode = 2'd2;
      cur_req = "R5";
      push_run(16'h2000, 16'h8000, 16);
      stall_cnt = 0;
      wr(3'd4, 8'h00);
      wait_idle("R5", 32);
      check_reg("R8", 3'd4, 8'hFF);

      // R11: control write during a run is ignored
      cur_req = "R11";
      video_mode = 2'd1;
      set_addrs(16'h3000, 16'h8400);
      push_run(16'h3000, 16'h8400, 64);
      stall_cnt = 0;
      wr(3'd4, 8'h03);
      idle_cycles(5);
      wr(3'd4, 8'h7F);
      wait_idle("R11", 128);
      check_reg("R11", 3'd4, 8'hFF);
      check_reg("R11", 3'd0, 8'h30);
      check_reg("R11", 3'd1, 8'h40);

      idle_cycles(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule